// File: doc/BRIEF.md
# Multi-Queue Word FIFO Manager

The block keeps up to eight independent FIFO queues of 32-bit words in a single shared buffer memory. A host reaches it over a simple synchronous register bus. Each access cycle is either a write (`wr_i`) or a read (`rd_i`). A write to a queue's access address appends a word to that queue. A read from the same address removes the oldest word and returns it on `rdata_o` one clock later. Every register read is returned the same way.

Each queue has a length, a nearly-empty threshold and a nearly-full threshold. Its four level flags are gathered into a packed status word. Each queue also has two sticky error flags that clear when read. For interrupts, each queue has an 8-way condition selector and an enable bit. A selected condition sets a sticky interrupt bit, which software clears by writing 1 to it. `irq_o` is the OR of all interrupt bits.

Register map (word addresses): `0x00+q` is the access address of queue q. `0x10+q` is the configuration of queue q. `0x20` is the level status word, `0x28` the error word and `0x30` the interrupt status. `0x31` holds the interrupt enables and `0x38` the condition selects. `NUM_Q` is a power of two from 2 to 8.

Top module: `multi_queue_mgr`

## Requirements
- R1: Words read from a queue's access address come back in the order they were written, on `rdata_o` one clock after the read. Queues do not disturb each other.
- R2: Each queue has a 4-bit level nibble at bit 4*q of word 0x20: bit 0 empty, bit 1 nearly empty, bit 2 nearly full, bit 3 full. After reset every queue shows 0x3, so eight queues read 0x33333333.
- R3: A 3-bit watermark code c stands for 0 entries when c=0, otherwise 2^(c-1) entries. Nearly empty holds when fill level <= the nearly-empty watermark. Nearly full holds when free space <= the nearly-full watermark.
- R4: Configuration bits [1:0] pick the length: 0=16, 1=32, 2=64 or 3=128 words. Full holds exactly at that fill level. The pointers wrap at the length.
- R5: A write to a full queue drops the word and sets the sticky overflow flag, which is bit 1 of the queue's error field.
- R6: A read from an empty queue returns 0, leaves the queue unchanged and sets the sticky underflow flag, which is bit 0 of the error field.
- R7: The error word at 0x28 holds queue q's 2-bit field at bit 2*q. Reading the word clears the flags it returned.
- R8: A write to 0x10+q loads the configuration: [1:0] length code, [4:2] nearly-empty code, [7:5] nearly-full code. It also empties the queue and clears its error flags. The configuration reads back at the same address.
- R9: Queue q's condition select sits at bits [4q+2:4q] of 0x38. Values 0 to 3 pick empty, nearly empty, nearly full and full. Values 4 to 7 pick the inverse of the same flag.
- R10: Interrupt bit q (address 0x30) is set on every cycle in which queue q's selected condition holds and enable bit q of 0x31 is set. Writing 1 to the bit clears it only if no new set arrives in that cycle. `irq_o` is high when any interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe (wins over `rd_i`) |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt |

## Verification
Interleaved pushes and pops on two queues show whether ordering is per queue or shared across queues. Filling a queue after a small offset forces its pointers to wrap. Stepping a 128-word queue across 63, 64, 65, 127 and 128 entries, with both watermarks at code 7, shows off-by-one errors in the watermark decode and in the full comparison. Interrupt selects 3 and 7 are tried on the same empty queue, and the inverse-select bit must change the result. A clear request is also issued while a condition still holds, to separate set priority from clear priority.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int MAX_LEN = 128;
  localparam int PTR_W   = $clog2(MAX_LEN);
  localparam int LVL_W   = PTR_W + 1;

  typedef struct packed {
    logic [2:0] nf_wm;
    logic [2:0] ne_wm;
    logic [1:0] len_code;
  } qm_cfg_t;

  function automatic logic [LVL_W-1:0] wm_entries(input logic [2:0] code);
    return (code == 3'd0) ? '0 : (LVL_W'(1) << (code - 3'd1));
  endfunction

  function automatic logic [LVL_W-1:0] len_words(input logic [1:0] code);
    return LVL_W'(16) << code;
  endfunction
endpackage

// File: rtl/qm_queue.sv
module qm_queue
  import qm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  qm_cfg_t          cfg_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             err_clr_i,
  output qm_cfg_t          cfg_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [3:0]       flags_o,
  output logic [1:0]       err_o,
  output logic             push_ok_o,
  output logic             pop_ok_o
);
  qm_cfg_t          cfg_q;
  logic [LVL_W-1:0] cnt_q, len, free;
  logic [PTR_W-1:0] wr_q, rd_q, mask;
  logic [1:0]       err_q;
  logic             empty, full, nempty, nfull;

  assign len    = len_words(cfg_q.len_code);
  assign free   = len - cnt_q;
  assign mask   = PTR_W'(len - LVL_W'(1));
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == len);
  assign nempty = (cnt_q <= wm_entries(cfg_q.ne_wm));
  assign nfull  = (free <= wm_entries(cfg_q.nf_wm));

  assign push_ok_o = push_i & ~full;
  assign pop_ok_o  = pop_i & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_i;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= (wr_q + PTR_W'(1)) & mask;
      if (pop_ok_o)  rd_q <= (rd_q + PTR_W'(1)) & mask;
      cnt_q <= cnt_q + LVL_W'(push_ok_o) - LVL_W'(pop_ok_o);
      err_q <= (err_clr_i ? 2'b00 : err_q) | {push_i & full, pop_i & empty};
    end
  end

  assign cfg_o    = cfg_q;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign flags_o  = {full, nfull, nempty, empty};
  assign err_o    = err_q;
endmodule

// File: rtl/qm_irq.sv
module qm_irq #(
  parameter int NUM_Q = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_Q-1:0][3:0] flags_i,
  input  logic [NUM_Q-1:0][2:0] sel_i,
  input  logic [NUM_Q-1:0]      en_i,
  input  logic                  clr_we_i,
  input  logic [NUM_Q-1:0]      clr_mask_i,
  output logic [NUM_Q-1:0]      stat_o,
  output logic                  irq_o
);
  logic [NUM_Q-1:0] hit, stat_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_src
    logic flag;
    assign flag   = flags_i[q][sel_i[q][1:0]];
    assign hit[q] = en_i[q] & (sel_i[q][2] ? ~flag : flag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~(clr_we_i ? clr_mask_i : '0)) | hit;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/multi_queue_mgr.sv
module multi_queue_mgr
  import qm_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [5:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int QI_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int MEM_D = NUM_Q * MAX_LEN;
  localparam logic [5:0] A_STAT = 6'h20;
  localparam logic [5:0] A_ERR  = 6'h28;
  localparam logic [5:0] A_IRQ  = 6'h30;
  localparam logic [5:0] A_IEN  = 6'h31;
  localparam logic [5:0] A_ISEL = 6'h38;

  logic [DATA_W-1:0] mem [MEM_D];

  logic                  rd_en, q_ok, acc_hit, cfg_hit;
  logic [QI_W-1:0]       qi;
  qm_cfg_t               q_cfg    [NUM_Q];
  logic [PTR_W-1:0]      q_wr_ptr [NUM_Q];
  logic [PTR_W-1:0]      q_rd_ptr [NUM_Q];
  logic [NUM_Q-1:0][3:0] q_flags;
  logic [NUM_Q-1:0][1:0] q_err;
  logic [NUM_Q-1:0]      push_ok, pop_ok;
  logic [NUM_Q-1:0]      irq_en, irq_stat;
  logic [NUM_Q-1:0][2:0] irq_sel;
  logic [31:0]           stat_word, err_word, sel_word;
  logic [DATA_W-1:0]     rd_mux;

  assign rd_en   = rd_i & ~wr_i;
  assign qi      = addr_i[QI_W-1:0];
  assign q_ok    = (addr_i[3:0] < 4'(NUM_Q));
  assign acc_hit = (addr_i[5:4] == 2'b00) & q_ok;
  assign cfg_hit = (addr_i[5:4] == 2'b01) & q_ok;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic sel;
    assign sel = (qi == QI_W'(q));
    qm_queue u_queue (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (wr_i & cfg_hit & sel),
      .cfg_i     (qm_cfg_t'(wdata_i[7:0])),
      .push_i    (wr_i & acc_hit & sel),
      .pop_i     (rd_en & acc_hit & sel),
      .err_clr_i (rd_en & (addr_i == A_ERR)),
      .cfg_o     (q_cfg[q]),
      .wr_ptr_o  (q_wr_ptr[q]),
      .rd_ptr_o  (q_rd_ptr[q]),
      .flags_o   (q_flags[q]),
      .err_o     (q_err[q]),
      .push_ok_o (push_ok[q]),
      .pop_ok_o  (pop_ok[q])
    );
  end

  // shared buffer, queue q owns words [q*MAX_LEN +: MAX_LEN]
  always_ff @(posedge clk_i) begin
    if (|push_ok) mem[{qi, q_wr_ptr[qi]}] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en  <= '0;
      irq_sel <= '0;
    end else if (wr_i) begin
      if (addr_i == A_IEN) irq_en <= wdata_i[NUM_Q-1:0];
      if (addr_i == A_ISEL)
        for (int q = 0; q < NUM_Q; q++) irq_sel[q] <= wdata_i[4*q +: 3];
    end
  end

  qm_irq #(.NUM_Q(NUM_Q)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flags_i    (q_flags),
    .sel_i      (irq_sel),
    .en_i       (irq_en),
    .clr_we_i   (wr_i & (addr_i == A_IRQ)),
    .clr_mask_i (wdata_i[NUM_Q-1:0]),
    .stat_o     (irq_stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    stat_word = '0;
    err_word  = '0;
    sel_word  = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      stat_word[4*q +: 4] = q_flags[q];
      err_word[2*q +: 2]  = q_err[q];
      sel_word[4*q +: 3]  = irq_sel[q];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (acc_hit)               rd_mux = pop_ok[qi] ? mem[{qi, q_rd_ptr[qi]}] : '0;
    else if (cfg_hit)          rd_mux = DATA_W'(q_cfg[qi]);
    else if (addr_i == A_STAT) rd_mux = DATA_W'(stat_word);
    else if (addr_i == A_ERR)  rd_mux = DATA_W'(err_word);
    else if (addr_i == A_IRQ)  rd_mux = DATA_W'(irq_stat);
    else if (addr_i == A_IEN)  rd_mux = DATA_W'(irq_en);
    else if (addr_i == A_ISEL) rd_mux = DATA_W'(sel_word);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/multi_queue_mgr_chk.sv
module multi_queue_mgr_chk #(
  parameter int NUM_Q  = 8,
  parameter int DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [5:0]            addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_Q-1:0][3:0] q_flags,
  input logic [NUM_Q-1:0][1:0] q_err,
  input logic [NUM_Q-1:0]      irq_stat
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
    assert_not_empty_and_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(q_flags[q][0] && q_flags[q][3]));

    assert_full_implies_nfull_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_flags[q][3] |-> q_flags[q][2]);

    assert_empty_implies_nempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_flags[q][0] |-> q_flags[q][1]);

    assert_overflow_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == 6'(q) && q_flags[q][3]) |=> q_err[q][1]);

    assert_underflow_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && addr_i == 6'(q) && q_flags[q][0]) |=> (q_err[q][0] && rdata_o == '0));

    assert_cfg_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == 6'(16 + q)) |=> (q_flags[q][0] && q_err[q] == 2'b00));

    assert_irq_clear_only_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_stat[q]) |-> $past(wr_i && addr_i == 6'h30 && wdata_i[q]));
  end
endmodule

bind multi_queue_mgr multi_queue_mgr_chk #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .q_flags  (q_flags),
  .q_err    (q_err),
  .irq_stat (irq_stat)
);

// File: tb/test_multi_queue_mgr.sv
module test_multi_queue_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4ns clk = ~clk;

  multi_queue_mgr i_multi_queue_mgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        is_rd;
    logic [5:0]  a;
    logic [31:0] d;  // write data, or expected read data
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 32'hA0000001},  // R1
    '{1'b0, 6'h00, 32'hA0000002},
    '{1'b0, 6'h01, 32'hB0000001},
    '{1'b1, 6'h20, 32'h33333300},  // R2
    '{1'b1, 6'h00, 32'hA0000001},  // R1 order
    '{1'b1, 6'h01, 32'hB0000001},
    '{1'b1, 6'h00, 32'hA0000002},
    '{1'b1, 6'h20, 32'h33333333},
    '{1'b0, 6'h12, 32'h00000028},  // R8 q2: ne code 2, nf code 1
    '{1'b1, 6'h12, 32'h00000028},
    '{1'b0, 6'h02, 32'h000000C1},
    '{1'b1, 6'h20, 32'h33333233},  // R3 level 1 <= 2
    '{1'b0, 6'h02, 32'h000000C2},
    '{1'b1, 6'h20, 32'h33333233},  // R3 level 2 <= 2
    '{1'b0, 6'h02, 32'h000000C3},
    '{1'b1, 6'h20, 32'h33333033},  // R3 level 3 > 2
    '{1'b1, 6'h02, 32'h000000C1},
    '{1'b1, 6'h20, 32'h33333233},
    '{1'b1, 6'h02, 32'h000000C2},
    '{1'b1, 6'h02, 32'h000000C3},
    '{1'b1, 6'h20, 32'h33333333},
    '{1'b1, 6'h28, 32'h00000000}   // R7 no errors
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R2", "reset rdata", rdata, 32'h0);
    chk("R10", "reset irq", {31'b0, irq}, 32'h0);
    bus_rd(6'h20, v); chk("R2", "reset status", v, 32'h33333333);
    bus_rd(6'h30, v); chk("R10", "reset irq stat", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        bus_rd(VEC[i].a, v);
        chk("R1/R2/R3", $sformatf("vec %0d", i), v, VEC[i].d);
      end else begin
        bus_wr(VEC[i].a, VEC[i].d);
      end
    end

    // R4 wrap and full at 16 on q3
    for (int i = 0; i < 3; i++) bus_wr(6'h03, 32'h300 + i);
    for (int i = 0; i < 3; i++) begin
      bus_rd(6'h03, v); chk("R1", "q3 pre", v, 32'h300 + i);
    end
    for (int i = 0; i < 15; i++) bus_wr(6'h03, 32'h3100 + i);
    bus_rd(6'h20, v); chk("R4", "q3 at 15", v, 32'h33330333);
    bus_wr(6'h03, 32'h310F);
    bus_rd(6'h20, v); chk("R4", "q3 full", v, 32'h3333C333);
    bus_wr(6'h03, 32'hDEAD0000);
    bus_rd(6'h28, v); chk("R5", "q3 overflow", v, 32'h00000080);
    bus_rd(6'h28, v); chk("R7", "err clear on read", v, 32'h0);
    for (int i = 0; i < 16; i++) begin
      bus_rd(6'h03, v); chk("R4", "q3 wrap order", v, 32'h3100 + i);
    end
    bus_rd(6'h20, v); chk("R4", "q3 drained", v, 32'h33333333);

    // R6 underflow on q4
    bus_rd(6'h04, v); chk("R6", "empty pop data", v, 32'h0);
    bus_rd(6'h28, v); chk("R6", "underflow flag", v, 32'h00000100);
    bus_wr(6'h04, 32'h44);
    bus_rd(6'h04, v); chk("R6", "pointers kept", v, 32'h44);

    // R3/R4 length 128, both watermarks code 7 on q5
    bus_wr(6'h15, 32'h000000FF);
    for (int i = 0; i < 63; i++) bus_wr(6'h05, 32'h50000000 + i);
    bus_rd(6'h20, v); chk("R3", "q5 at 63", v, 32'h33233333);
    bus_wr(6'h05, 32'h5000003F);
    bus_rd(6'h20, v); chk("R3", "q5 at 64", v, 32'h33633333);
    bus_wr(6'h05, 32'h50000040);
    bus_rd(6'h20, v); chk("R3", "q5 at 65", v, 32'h33433333);
    for (int i = 65; i < 127; i++) bus_wr(6'h05, 32'h50000000 + i);
    bus_rd(6'h20, v); chk("R4", "q5 at 127", v, 32'h33433333);
    bus_wr(6'h05, 32'h5000007F);
    bus_rd(6'h20, v); chk("R4", "q5 full 128", v, 32'h33C33333);
    bus_rd(6'h05, v); chk("R1", "q5 oldest", v, 32'h50000000);

    // R8 config resets queue and errors
    bus_wr(6'h15, 32'h0);
    bus_rd(6'h07, v);
    bus_wr(6'h07, 32'h71);
    bus_wr(6'h07, 32'h72);
    bus_wr(6'h17, 32'h0);
    bus_rd(6'h20, v); chk("R8", "cfg empties", v, 32'h33333333);
    bus_rd(6'h28, v); chk("R8", "cfg clears err", v, 32'h0);
    bus_rd(6'h07, v); chk("R8", "pop after cfg", v, 32'h0);
    bus_rd(6'h28, v);

    // R9/R10 interrupts
    bus_wr(6'h38, 32'h04000000);   // q6 not empty, q7 empty
    bus_wr(6'h31, 32'h40);
    idle();
    chk("R9", "not-empty on empty q6", {31'b0, irq}, 32'h0);
    bus_wr(6'h06, 32'h66);
    idle();
    chk("R10", "irq set", {31'b0, irq}, 32'h1);
    bus_rd(6'h30, v); chk("R10", "irq stat q6", v, 32'h40);
    bus_rd(6'h06, v);
    bus_wr(6'h30, 32'h40);
    chk("R10", "w1c cleared", {31'b0, irq}, 32'h0);
    bus_rd(6'h30, v); chk("R10", "stat after w1c", v, 32'h0);
    bus_wr(6'h31, 32'h80);
    idle();
    bus_rd(6'h30, v); chk("R9", "empty select q7", v, 32'h80);
    bus_wr(6'h30, 32'h80);
    bus_rd(6'h30, v); chk("R10", "set beats clear", v, 32'h80);
    bus_wr(6'h31, 32'h00);
    bus_wr(6'h30, 32'h80);
    chk("R10", "irq low", {31'b0, irq}, 32'h0);
    bus_wr(6'h38, 32'h03000000);   // q6 full
    bus_wr(6'h31, 32'h40);
    idle();
    chk("R9", "full select", {31'b0, irq}, 32'h0);
    bus_wr(6'h38, 32'h07000000);   // q6 not full
    idle();
    chk("R9", "not-full select", {31'b0, irq}, 32'h1);
    bus_rd(6'h38, v); chk("R9", "select readback", v, 32'h07000000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule